// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Timer

This block guards the slave side of a two-wire serial bus against a line that never comes back up. It observes the already-synchronized clock line and data-in line and keeps a cycle count for as long as at least one of them is low. The count is discarded only when both lines are seen high together. If the count reaches a configured limit, the block drives a single-cycle reset pulse into the protocol engine. The engine then drops whatever transfer it was in. Normal traffic can start again once the bus has been released.

The timeout is a parameter given in clock cycles. The design also takes a permitted window, expressed in cycles. The default values match a 100 MHz clock and a window of 20 ms to 33 ms. Elaboration rejects any timeout that falls outside the window. The timer fires at most once for each stuck episode and re-arms only after both lines have been seen high. A control-register bit can switch the timer off. While the timer is off, its count is held at zero.

There is no data stream through this block. All pins are plain level or pulse signals, so no valid/ready handshake or back-pressure applies.

Top module: `i2c_stuck_guard`

## Requirements
- R1: While enabled and armed, every clock edge that samples clock-line low or data-line low (either one) advances the hold count. The edge that samples the TIMEOUT_CYC-th consecutive such cycle makes `engine_rst` high in the following cycle.
- R2: The hold count is cleared only by an edge that samples both lines high (`scl_in`=1 and `sda_in`=1). A single such cycle restarts the count from zero. Toggling one line while the other stays low does not clear the count.
- R3: Only one pulse is produced per stuck episode. After firing, the timer stays silent until an edge samples both lines high, and it is then re-armed.
- R4: `engine_rst` is never high for two consecutive cycles.
- R5: While `guard_en` is 0 at a clock edge, no pulse is produced in the next cycle and the hold count is forced to zero.
- R6: When `guard_en` goes from 0 to 1 while a line is still low, counting starts fresh. A full TIMEOUT_CYC enabled low cycles are needed before the pulse.
- R7: Recovery never happens before WIN_LO_CYC consecutive low cycles, and it always happens by WIN_HI_CYC cycles. A TIMEOUT_CYC outside [WIN_LO_CYC, WIN_HI_CYC] is rejected at elaboration.
- R8: After reset, `engine_rst` is 0, the hold count is zero and the timer is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Synchronized bus clock level |
| sda_in | input | 1 | Synchronized bus data-in level |
| guard_en | input | 1 | Timer enable from the control register (1 = enabled) |
| engine_rst | output | 1 | One-cycle reset pulse to the protocol engine |

## Verification
The bound checker keeps its own run-length count of enabled low cycles and its own record of whether the current episode has already fired. On every cycle it checks three things:
- the pulse appears exactly when that independent count reaches the timeout in an unfired episode (R1);
- the pulse is one cycle wide (R4);
- a both-high cycle or a disabled cycle is never followed by a pulse (R2, R5).

Some behaviours can only be shown by the bench's scenarios. One is that a stuck episode yields only one pulse until a both-high cycle re-arms the timer. Another is that re-enabling mid-episode restarts the count. A third is that the fire point lands inside the permitted window for every hold length swept, on either line or on both.

// File: rtl/isg_pkg.sv
package isg_pkg;
  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_SPENT = 1'b1
  } arm_state_e;
endpackage

// File: rtl/isg_line_watch.sv
module isg_line_watch (
  input  logic scl_in,
  input  logic sda_in,
  output logic any_low,
  output logic all_high
);
  always_comb begin
    any_low  = !scl_in || !sda_in;
    all_high = scl_in && sda_in;
  end
endmodule

// File: rtl/isg_hold_counter.sv
module isg_hold_counter #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic at_last
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_comb at_last = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (!at_last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/isg_fire_ctl.sv
module isg_fire_ctl
  import isg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic at_last,
  input  logic all_high,
  output logic armed,
  output logic pulse
);
  arm_state_e st_q;
  logic       fire;

  always_comb begin
    armed = (st_q == ST_ARMED);
    fire  = run && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ARMED;
      pulse <= 1'b0;
    end else begin
      pulse <= fire;
      if (fire) begin
        st_q <= ST_SPENT;
      end else if (all_high) begin
        st_q <= ST_ARMED;
      end
    end
  end
endmodule

// File: rtl/i2c_stuck_guard.sv
module i2c_stuck_guard #(
  parameter int unsigned TIMEOUT_CYC = 2_600_000,
  parameter int unsigned WIN_LO_CYC  = 2_000_000,
  parameter int unsigned WIN_HI_CYC  = 3_300_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic guard_en,
  output logic engine_rst
);
  generate
    if (TIMEOUT_CYC < WIN_LO_CYC || TIMEOUT_CYC > WIN_HI_CYC || TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("i2c_stuck_guard: TIMEOUT_CYC outside permitted window (R7)");
    end
  endgenerate

  logic any_low;
  logic all_high;
  logic armed;
  logic run;
  logic at_last;

  isg_line_watch u_watch (
    .scl_in  (scl_in),
    .sda_in  (sda_in),
    .any_low (any_low),
    .all_high(all_high)
  );

  always_comb run = guard_en && any_low && armed;

  isg_hold_counter #(.LIMIT(TIMEOUT_CYC)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .at_last(at_last)
  );

  isg_fire_ctl u_fire (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .at_last (at_last),
    .all_high(all_high),
    .armed   (armed),
    .pulse   (engine_rst)
  );
endmodule

// File: rtl/isg_checker.sv
module isg_checker #(
  parameter int unsigned TIMEOUT_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_in,
  input logic guard_en,
  input logic engine_rst
);
  localparam int unsigned RW = $clog2(TIMEOUT_CYC + 2);
  localparam logic [RW-1:0] TGT = RW'(TIMEOUT_CYC);
  localparam logic [RW-1:0] SAT = RW'(TIMEOUT_CYC + 1);

  logic [RW-1:0] lowrun;
  logic          spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowrun <= '0;
      spent  <= 1'b0;
    end else begin
      if (!guard_en || (scl_in && sda_in)) lowrun <= '0;
      else if (lowrun != SAT)              lowrun <= lowrun + 1'b1;
      if (engine_rst)                      spent <= 1'b1;
      else if (scl_in && sda_in)           spent <= 1'b0;
    end
  end

  // R1: pulse exactly when the independent run length hits the timeout
  a_r1_fire_point: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |-> (lowrun == TGT));
  a_r1_fire_due: assert property (@(posedge clk) disable iff (!rst_n)
    (lowrun == TGT && !spent) |-> engine_rst);
  a_r2_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && sda_in) |=> !engine_rst);
  a_r4_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |=> !engine_rst);
  a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_en |=> !engine_rst);
endmodule

bind i2c_stuck_guard isg_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_in    (sda_in),
  .guard_en  (guard_en),
  .engine_rst(engine_rst)
);

// File: tb/sim_i2c_stuck_guard.sv
module sim_i2c_stuck_guard;
  localparam int unsigned T  = 20;
  localparam int unsigned LO = 16;
  localparam int unsigned HI = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic guard_en = 1'b1;
  logic engine_rst;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  i2c_stuck_guard #(.TIMEOUT_CYC(T), .WIN_LO_CYC(LO), .WIN_HI_CYC(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .guard_en(guard_en), .engine_rst(engine_rst)
  );

  task automatic chk(input logic exp, input string req);
    n_vec++;
    if (engine_rst !== exp) begin
      n_bad++;
      $display("FAIL %s: engine_rst=%b expected %b at %0t", req, engine_rst, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic d, input logic e);
    scl_in = s; sda_in = d; guard_en = e;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      step(1'b1, 1'b1, 1'b1);
      chk(1'b0, "R2");
    end
  endtask

  initial begin
    #20;
    chk(1'b0, "R8");
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1/R7: sweep hold length on clock line, data line, both
    for (int line = 0; line < 3; line++) begin
      for (int d = 1; d <= int'(T) + 6; d++) begin
        idle(2);
        for (int i = 1; i <= d; i++) begin
          step(line == 1, line == 0, 1'b1);
          chk(i == int'(T), "R1");
          if (i < int'(LO)) chk(1'b0, "R7");
        end
        step(1'b1, 1'b1, 1'b1);
        chk(1'b0, "R4");
      end
    end

    // R2: one both-high cycle restarts the count
    idle(2);
    for (int i = 1; i <= 15; i++) begin step(1'b0, 1'b1, 1'b1); chk(1'b0, "R2"); end
    step(1'b1, 1'b1, 1'b1); chk(1'b0, "R2");
    for (int i = 1; i <= int'(T); i++) begin step(1'b1, 1'b0, 1'b1); chk(i == int'(T), "R2"); end

    // R2: alternating lines, never both high, counts continuously
    idle(2);
    for (int i = 1; i <= int'(T) + 3; i++) begin
      step(i % 2 == 0, i % 2 == 1, 1'b1);
      chk(i == int'(T), "R2");
    end

    // R3: long stuck episode gives one pulse; no re-arm without both high
    idle(2);
    for (int i = 1; i <= 3 * int'(T); i++) begin
      step(1'b0, (i > 30) && (i % 3 == 0), 1'b1);
      chk(i == int'(T), "R3");
    end
    for (int i = 1; i <= 10; i++) begin step(1'b1, 1'b0, 1'b1); chk(1'b0, "R3"); end
    step(1'b1, 1'b1, 1'b1); chk(1'b0, "R3");
    for (int i = 1; i <= int'(T) + 2; i++) begin step(1'b0, 1'b0, 1'b1); chk(i == int'(T), "R3"); end

    // R5: disabled, long hold, no pulse
    idle(2);
    for (int i = 1; i <= 2 * int'(T); i++) begin step(1'b0, 1'b0, 1'b0); chk(1'b0, "R5"); end
    // R6: enable mid-hold starts fresh
    for (int i = 1; i <= int'(T) + 2; i++) begin step(1'b0, 1'b0, 1'b1); chk(i == int'(T), "R6"); end

    // R5/R6: partial count, one disabled cycle, full count needed again
    idle(2);
    for (int i = 1; i <= 15; i++) begin step(1'b0, 1'b1, 1'b1); chk(1'b0, "R6"); end
    step(1'b0, 1'b1, 1'b0); chk(1'b0, "R5");
    for (int i = 1; i <= int'(T); i++) begin step(1'b0, 1'b1, 1'b1); chk(i == int'(T), "R6"); end

    // R8: reset mid-count clears it
    idle(2);
    for (int i = 1; i <= 15; i++) begin step(1'b0, 1'b0, 1'b1); chk(1'b0, "R8"); end
    rst_n = 1'b0;
    #2;
    chk(1'b0, "R8");
    step(1'b0, 1'b0, 1'b1);
    rst_n = 1'b1;
    for (int i = 1; i <= int'(T); i++) begin step(1'b0, 1'b0, 1'b1); chk(i == int'(T), "R8"); end
    idle(2);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule